// File: doc/BRIEF.md
# Four-Channel DMA Request/Acknowledge Handshake

This block runs the peripheral side of a four-channel DMA handshake. Each channel has an active-low request line, an active-low acknowledge line and its own word counter. The request lines are captured on the falling clock edge. On the next rising edge, the block qualifies them against each channel's enable and mask state. It then picks one channel by fixed priority and holds that channel's acknowledge low while the transfer runs.

A word completes on each rising edge where bus ready (`rdy_n`) is low. A channel set for double-word transfers always finishes both words of a pair before the acknowledge can be released. A first-word flag shows which half of the pair is in progress. Each completed word decrements the channel's counter. When the counter reaches zero, the channel switches itself off and `done_n` pulses low for one clock.

There is no data stream through this block. Every pin is a plain level or strobe, and `ld_valid` is a one-cycle write strobe with no back-pressure. Address generation and bus arbitration live elsewhere.

Top module: `dma_handshake`

## Requirements
- R1: On reset, all `ack_n` bits are high, `done_n` is high, `first_word` is high and every channel is disabled.
- R2: A channel is served only if its captured request is low, it is enabled (holds a nonzero count) and its `chan_mask` bit is 0. A masked or disabled channel is ignored.
- R3: When several qualified channels request in the same cycle, channel 0 wins and channel 3 has the lowest priority.
- R4: `req_n` is sampled on the falling clock edge. From idle, the acknowledge of the selected channel goes low on the following rising edge. At most one `ack_n` bit is ever low.
- R5: While a channel is served, its acknowledge stays low on every edge where `rdy_n` is high, even if the request has been withdrawn.
- R6: At a completed word (ready low) that ends a transfer unit, the acknowledge rises if the captured request is high. If the request is still low, service continues with the acknowledge held low.
- R7: Each completed word decrements the served channel's counter. When the counter reaches zero, the acknowledge rises regardless of the request, and the channel disables itself until it is loaded again.
- R8: `done_n` is low for exactly one clock, in the cycle after the word that brought a counter to zero, and at no other time.
- R9: For a channel whose `dbl_word` bit is 1, the first word of a pair shows `first_word`=1 and the second shows `first_word`=0. The acknowledge cannot be released between the two words. For single-word channels, and while idle, `first_word` is 1.
- R10: A pulse on `ld_valid` writes `ld_cnt` into the counter of channel `ld_ch`. The channel is enabled if the value is nonzero and disabled if it is zero. A load aimed at the channel currently being served is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Per-channel request, active low, bit i = channel i |
| rdy_n | input | 1 | Bus ready, active low; low completes the current word |
| ld_valid | input | 1 | One-cycle counter load strobe |
| ld_ch | input | 2 | Channel index for the load |
| ld_cnt | input | 8 | Word count to load |
| chan_mask | input | 4 | Per-channel mask, 1 blocks service |
| dbl_word | input | 4 | Per-channel double-word mode, 1 = words in pairs |
| ack_n | output | 4 | Per-channel acknowledge, active low |
| done_n | output | 1 | End-of-transfer strobe, low for one clock |
| first_word | output | 1 | 1 on the first word of a pair, 0 on the second |

## Verification
The bench withdraws a request while ready is high. A design that releases on the request alone drops the acknowledge early. It also holds a request low through a completed word, where a design that releases on every ready would stop service. Simultaneous requests from a masked channel and a live channel catch a design with the wrong priority or a missing mask qualifier. A double-word pair whose count runs out on the second word checks both the first-word flag and the single-clock done pulse. A counter load aimed at the channel in service checks that the load is ignored: if it were taken, the done strobe would go missing.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_BUSY = 1'b1
  } hs_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_n,
  output logic [NCH-1:0] req_q
);
  // Capture on the falling edge so the rising-edge logic sees a settled value.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '1;
    else        req_q <= req_n;
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  output logic           hit,
  output logic [IW-1:0]  idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    // Scan from the lowest priority upward so channel 0 overrides the rest.
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic          en,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en    <= 1'b0;
    end else if (ld) begin
      cnt_q <= ld_val;
      en    <= (ld_val != '0);
    end else if (dec && en) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) en <= 1'b0;
    end
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_handshake.sv
module dma_handshake
  import dma_hs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_n,
  input  logic           rdy_n,
  input  logic           ld_valid,
  input  logic [IW-1:0]  ld_ch,
  input  logic [CW-1:0]  ld_cnt,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] dbl_word,
  output logic [NCH-1:0] ack_n,
  output logic           done_n,
  output logic           first_word
);
  hs_state_e      st_q;
  logic [IW-1:0]  cur_q;
  logic           wsel_q;
  logic [NCH-1:0] req_s;
  logic [NCH-1:0] en_v, last_v, cand;
  logic           pick_hit;
  logic [IW-1:0]  pick_idx;
  logic           busy, word_done, unit_end, cnt_end, release_now;

  dma_req_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .req_q(req_s)
  );

  assign busy = (st_q == HS_BUSY);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic ld_g, dec_g;
    assign ld_g  = ld_valid && (ld_ch == IW'(g)) && !(busy && cur_q == IW'(g));
    assign dec_g = word_done && (cur_q == IW'(g));
    dma_chan_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld(ld_g), .ld_val(ld_cnt),
      .dec(dec_g), .en(en_v[g]), .last(last_v[g])
    );
  end

  assign cand = ~req_s & en_v & ~chan_mask;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .cand(cand), .hit(pick_hit), .idx(pick_idx)
  );

  assign word_done   = busy && !rdy_n;
  assign unit_end    = !dbl_word[cur_q] || wsel_q;
  assign cnt_end     = word_done && last_v[cur_q];
  assign release_now = cnt_end || (word_done && unit_end && req_s[cur_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      cur_q  <= '0;
      wsel_q <= 1'b0;
      ack_n  <= '1;
      done_n <= 1'b1;
    end else begin
      done_n <= 1'b1;
      if (!busy) begin
        if (pick_hit) begin
          st_q   <= HS_BUSY;
          cur_q  <= pick_idx;
          wsel_q <= 1'b0;
          ack_n  <= ~(NCH'(1) << pick_idx);
        end
      end else if (word_done) begin
        if (release_now) begin
          st_q   <= HS_IDLE;
          wsel_q <= 1'b0;
          ack_n  <= '1;
          done_n <= !cnt_end;
        end else begin
          wsel_q <= dbl_word[cur_q] ? !wsel_q : 1'b0;
        end
      end
    end
  end

  assign first_word = !wsel_q;

  // R4: never more than one acknowledge low
  a_r4_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ack_n));

  // R5: acknowledge pattern frozen while ready is high during service
  a_r5_hold_unready: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n != '1 && rdy_n) |=> (ack_n == $past(ack_n)));

  // R8: done strobe lasts a single clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !done_n |=> done_n);

  // R8: done only follows a cycle of service
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !done_n |-> ($past(ack_n) != '1));

  // R9: second-word flag only while a channel is acknowledged
  a_r9_first_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !first_word |-> (ack_n != '1));
endmodule

// File: tb/sim_dma_handshake.sv
module sim_dma_handshake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       rdy_n = 1'b1;
  logic       ld_valid = 1'b0;
  logic [1:0] ld_ch = '0;
  logic [7:0] ld_cnt = '0;
  logic [3:0] chan_mask = 4'b1000;
  logic [3:0] dbl_word = 4'b0010;
  logic [3:0] ack_n;
  logic       done_n, first_word;

  int errs = 0;
  int total = 0;

  always #10 clk = ~clk;

  dma_handshake u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .rdy_n(rdy_n),
    .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_cnt(ld_cnt),
    .chan_mask(chan_mask), .dbl_word(dbl_word),
    .ack_n(ack_n), .done_n(done_n), .first_word(first_word)
  );

  // {req_n, rdy_n, expected ack_n, expected done_n, expected first_word}
  localparam logic [10:0] VEC [16] = '{
    {4'b1111, 1'b1, 4'b1111, 1'b1, 1'b1},
    {4'b1001, 1'b1, 4'b1101, 1'b1, 1'b1},
    {4'b1001, 1'b0, 4'b1101, 1'b1, 1'b0},
    {4'b1001, 1'b0, 4'b1111, 1'b0, 1'b1},
    {4'b1001, 1'b1, 4'b1011, 1'b1, 1'b1},
    {4'b1011, 1'b1, 4'b1011, 1'b1, 1'b1},
    {4'b1111, 1'b1, 4'b1011, 1'b1, 1'b1},
    {4'b1111, 1'b0, 4'b1111, 1'b1, 1'b1},
    {4'b0110, 1'b1, 4'b1110, 1'b1, 1'b1},
    {4'b0110, 1'b0, 4'b1110, 1'b1, 1'b1},
    {4'b0110, 1'b0, 4'b1110, 1'b1, 1'b1},
    {4'b0110, 1'b0, 4'b1111, 1'b0, 1'b1},
    {4'b0110, 1'b1, 4'b1111, 1'b1, 1'b1},
    {4'b1011, 1'b1, 4'b1011, 1'b1, 1'b1},
    {4'b1011, 1'b0, 4'b1111, 1'b0, 1'b1},
    {4'b1111, 1'b1, 4'b1111, 1'b1, 1'b1}
  };

  function automatic string row_tag(int i);
    case (i)
      1:       return "R3";
      2:       return "R9";
      3:       return "R7";
      4, 5:    return "R2";
      6:       return "R5";
      7:       return "R6";
      8:       return "R2";
      9, 10:   return "R6";
      11, 14:  return "R8";
      12:      return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag, logic [3:0] a, logic d, logic f);
    chk({tag, " ack_n"}, 32'(ack_n), 32'(a));
    chk({tag, " done_n"}, 32'(done_n), 32'(d));
    chk({tag, " first_word"}, 32'(first_word), 32'(f));
  endtask

  task automatic load(logic [1:0] ch, logic [7:0] v);
    ld_valid = 1'b1; ld_ch = ch; ld_cnt = v;
    @(posedge clk); #1;
    ld_valid = 1'b0;
  endtask

  task automatic cyc(logic [3:0] r, logic y);
    req_n = r; rdy_n = y;
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 100000);
    errs++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 reset", 4'b1111, 1'b1, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    load(2'd0, 8'd3);
    load(2'd1, 8'd2);
    load(2'd2, 8'd2);
    load(2'd3, 8'd5);
    for (int i = 0; i < 16; i++) begin
      cyc(VEC[i][10:7], VEC[i][6]);
      chk_all(row_tag(i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R2: unmasking channel 3 lets it be served
    chan_mask = 4'b0000;
    cyc(4'b0111, 1'b1);
    chk_all("R2 unmask", 4'b0111, 1'b1, 1'b1);
    // R6: withdrawn request with ready releases; count 5->4, so no done
    cyc(4'b1111, 1'b0);
    chk_all("R6 release", 4'b1111, 1'b1, 1'b1);

    // R10: zero load leaves channel 0 disabled
    load(2'd0, 8'd0);
    cyc(4'b1110, 1'b1);
    chk_all("R10 zero load", 4'b1111, 1'b1, 1'b1);

    // R10: load aimed at the served channel is ignored
    load(2'd2, 8'd1);
    cyc(4'b1011, 1'b1);
    chk_all("R10 serve", 4'b1011, 1'b1, 1'b1);
    ld_valid = 1'b1; ld_ch = 2'd2; ld_cnt = 8'd9;
    cyc(4'b1011, 1'b1);
    ld_valid = 1'b0;
    chk_all("R10 busy load", 4'b1011, 1'b1, 1'b1);
    cyc(4'b1011, 1'b0);
    chk_all("R10 count kept", 4'b1111, 1'b0, 1'b1);
    cyc(4'b1011, 1'b1);
    chk_all("R7 disabled", 4'b1111, 1'b1, 1'b1);

    // R1: reset in the middle of a transfer
    cyc(4'b0111, 1'b1);
    chk_all("R4 ch3", 4'b0111, 1'b1, 1'b1);
    rst_n = 1'b0;
    #2;
    chk_all("R1 mid reset", 4'b1111, 1'b1, 1'b1);
    rst_n = 1'b1;
    cyc(4'b0111, 1'b1);
    chk_all("R1 disabled after reset", 4'b1111, 1'b1, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule